// File: doc/BRIEF.md
# Request-Paced Single-Channel DMA with Circular Reload

This block is one DMA channel that copies elements from a source address to a destination address. Each beat is started by a request from a peripheral. For every request it issues one read beat on a simple memory master port, keeps the returned word, and then issues one write beat with byte enables that match the destination element. The source and destination element sizes are set independently. Each address either advances by its element size after every beat or stays fixed, which is the usual case for a peripheral data register.

Software programs the channel through a small word-addressed register port: two source addresses, a destination address, an element count and a control word. Enabling the channel copies the programmed values into working registers. When the count runs out, the channel sets a sticky done flag and can raise an interrupt.

In non-circular mode the channel then switches itself off. In circular mode it reloads its working registers from the programmed copies and keeps serving requests. In double-buffer mode each completion flips a status bit that selects which of the two source addresses the next pass reads from.

Top module: `dma_circ_chan`

## Requirements
- R1: Each accepted peripheral request produces exactly one read beat, then one cycle without a bus request while read data returns, then one write beat. `periph_ack` pulses in the cycle the write beat is accepted.
- R2: Size codes are 0 = byte, 1 = halfword and 2 = word.
  - Read side: the source element is taken from the byte lanes chosen by the low source address bits.
  - Write side: the element is zero-extended or truncated to the destination size and placed on the lanes chosen by the low destination address bits.
  - Write byte enables are one lane at addr[1:0] for a byte, lanes {addr[1],0} and {addr[1],1} for a halfword, and all four lanes for a word.
- R3: After every beat, each address advances by its own element size (1, 2 or 4) if its increment bit is set. Otherwise it keeps its value.
- R4: While `mem_busy` is high, a pending read or write keeps `mem_req`, `mem_we`, `mem_addr` and `mem_be` unchanged. The beat completes only in a cycle with `mem_busy` low.
- R5: Completing the last element sets the done flag (STATUS bit 0). The done flag stays set until cleared. `irq` is high exactly while the done flag and the interrupt-enable bit are both set.
- R6: Writing 1 to STATUS bit 0 clears the done flag. If a completion happens in the same cycle, the flag stays set.
- R7: Without circular mode, completion clears the enable bit. Afterwards, requests produce no acknowledge and no bus access.
- R8: With circular mode set, completion restores the working source address, destination address and count from the programmed values, and the channel stays enabled.
- R9: With double-buffer mode set, each completion toggles the current-buffer bit (STATUS bit 1). A pass starts from source B when the bit is 1 and from source A when it is 0.
- R10: Enabling with a count of zero sets the done flag on the next cycle, clears the enable bit, and makes no bus access.
- R11: A 0-to-1 write of the enable bit loads the working registers from the programmed ones. Reading offset 6 returns the remaining count.
- R12: Register offsets: 0 CTRL, 1 source A, 2 source B, 3 destination, 4 count, 5 STATUS, 6 remaining count. CTRL bits:
  - bit 0: enable
  - bit 1: circular
  - bit 2: double-buffer
  - bit 3: interrupt enable
  - bit 4: source increment
  - bit 5: destination increment
  - bits 7:6: source size
  - bits 9:8: destination size

  All registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| periph_req | input | 1 | Peripheral request, held until acknowledged |
| periph_ack | output | 1 | One beat finished |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read is accepted |
| mem_busy | input | 1 | Bus cannot accept the current beat |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The checker watches four rules on every cycle:
- the read → gap → write beat order;
- bus outputs held stable under `mem_busy`;
- byte-enable population against the destination size;
- a disabled, idle channel never issuing a request.

The bench scenarios are the only place that shows the data results. These are:
- lane extraction and placement across all size and increment combinations;
- circular reload and source alternation in double-buffer mode;
- sticky-flag priority against a simultaneous clear;
- zero-count completion without bus traffic.

// File: rtl/dma_circ_pkg.sv
package dma_circ_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_RDW  = 2'd2,
        ST_WR   = 2'd3
    } dma_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_SRCA = 3'd1;
    localparam logic [2:0] A_SRCB = 3'd2;
    localparam logic [2:0] A_DST  = 3'd3;
    localparam logic [2:0] A_CNT  = 3'd4;
    localparam logic [2:0] A_STAT = 3'd5;
    localparam logic [2:0] A_REM  = 3'd6;

    // bytes moved per element for a size code
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    // data mask for a size code
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_lane_map.sv
module dma_lane_map
    import dma_circ_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic [3:0] be,
    output logic [4:0] shift
);
    always_comb begin
        case (size)
            SZ_BYTE: begin
                be    = 4'b0001 << addr_lo;
                shift = {addr_lo, 3'b000};
            end
            SZ_HALF: begin
                be    = addr_lo[1] ? 4'b1100 : 4'b0011;
                shift = {addr_lo[1], 4'b0000};
            end
            default: begin
                be    = 4'b1111;
                shift = 5'd0;
            end
        endcase
    end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_circ_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic          inc,
    input  logic [1:0]    size,
    output logic [AW-1:0] next
);
    always_comb begin
        next = inc ? addr + AW'(size_bytes(size)) : addr;
    end
endmodule

// File: rtl/dma_circ_chan.sv
module dma_circ_chan
    import dma_circ_pkg::*;
#(
    parameter int unsigned AW = 32,  // at most 32
    parameter int unsigned CW = 16   // at most 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_busy,
    output logic          irq
);

    typedef struct packed {
        dma_state_e    st;
        logic          en;
        logic          circ;
        logic          dbuf;
        logic          irq_en;
        logic          src_inc;
        logic          dst_inc;
        logic [1:0]    src_sz;
        logic [1:0]    dst_sz;
        logic [AW-1:0] src_a;
        logic [AW-1:0] src_b;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [AW-1:0] src_w;
        logic [AW-1:0] dst_w;
        logic [CW-1:0] cnt_w;
        logic          cur;
        logic          done;
        logic [31:0]   rbuf;
    } chan_t;

    chan_t q, d;

    logic [3:0]    src_be, dst_be;
    logic [4:0]    src_sh, dst_sh;
    logic [AW-1:0] src_nx, dst_nx;
    logic [31:0]   elem, wr_data;
    logic          beat_done, fin_beat, fin_zero, cur_nx;

    // lane decode for the read side and the write side
    dma_lane_map u_src_lane (.addr_lo(q.src_w[1:0]), .size(q.src_sz), .be(src_be), .shift(src_sh));
    dma_lane_map u_dst_lane (.addr_lo(q.dst_w[1:0]), .size(q.dst_sz), .be(dst_be), .shift(dst_sh));

    dma_addr_step #(.AW(AW)) u_src_step (.addr(q.src_w), .inc(q.src_inc), .size(q.src_sz), .next(src_nx));
    dma_addr_step #(.AW(AW)) u_dst_step (.addr(q.dst_w), .inc(q.dst_inc), .size(q.dst_sz), .next(dst_nx));

    assign elem    = (q.rbuf >> src_sh) & size_mask(q.src_sz);
    assign wr_data = (elem & size_mask(q.dst_sz)) << dst_sh;

    always_comb begin
        d         = q;
        beat_done = (q.st == ST_WR) && !mem_busy;
        fin_beat  = beat_done && (q.cnt_w == CW'(1));
        fin_zero  = (q.st == ST_IDLE) && q.en && (q.cnt_w == '0);
        cur_nx    = q.cur ^ (fin_beat & q.dbuf);

        // beat sequencing
        case (q.st)
            ST_IDLE: if (q.en && (q.cnt_w != '0) && periph_req) d.st = ST_RD;
            ST_RD:   if (!mem_busy) d.st = ST_RDW;
            ST_RDW: begin
                d.rbuf = mem_rdata;
                d.st   = ST_WR;
            end
            ST_WR: if (!mem_busy) begin
                d.st    = ST_IDLE;
                d.src_w = src_nx;
                d.dst_w = dst_nx;
                d.cnt_w = q.cnt_w - CW'(1);
            end
            default: d.st = ST_IDLE;
        endcase

        // end of a pass
        if (fin_beat) begin
            d.cur = cur_nx;
            if (q.circ) begin
                d.src_w = (q.dbuf && cur_nx) ? q.src_b : q.src_a;
                d.dst_w = q.dst;
                d.cnt_w = q.cnt;
            end else begin
                d.en = 1'b0;
            end
        end
        if (fin_zero) d.en = 1'b0;

        // sticky flag: completion beats a clear
        if (fin_beat || fin_zero)
            d.done = 1'b1;
        else if (reg_we && (reg_addr == A_STAT) && reg_wdata[0])
            d.done = 1'b0;

        // software writes
        if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    d.en      = reg_wdata[0];
                    d.circ    = reg_wdata[1];
                    d.dbuf    = reg_wdata[2];
                    d.irq_en  = reg_wdata[3];
                    d.src_inc = reg_wdata[4];
                    d.dst_inc = reg_wdata[5];
                    d.src_sz  = reg_wdata[7:6];
                    d.dst_sz  = reg_wdata[9:8];
                    if (reg_wdata[0] && !q.en) begin
                        d.src_w = (reg_wdata[2] && q.cur) ? q.src_b : q.src_a;
                        d.dst_w = q.dst;
                        d.cnt_w = q.cnt;
                    end
                end
                A_SRCA:  d.src_a = reg_wdata[AW-1:0];
                A_SRCB:  d.src_b = reg_wdata[AW-1:0];
                A_DST:   d.dst   = reg_wdata[AW-1:0];
                A_CNT:   d.cnt   = reg_wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= chan_t'('0);
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[9:0] = {q.dst_sz, q.src_sz, q.dst_inc, q.src_inc,
                                      q.irq_en, q.dbuf, q.circ, q.en};
            A_SRCA: reg_rdata[AW-1:0] = q.src_a;
            A_SRCB: reg_rdata[AW-1:0] = q.src_b;
            A_DST:  reg_rdata[AW-1:0] = q.dst;
            A_CNT:  reg_rdata[CW-1:0] = q.cnt;
            A_STAT: reg_rdata[1:0]    = {q.cur, q.done};
            A_REM:  reg_rdata[CW-1:0] = q.cnt_w;
            default: ;
        endcase
    end

    assign mem_req    = (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_we     = (q.st == ST_WR);
    assign mem_addr   = (q.st == ST_WR) ? q.dst_w : q.src_w;
    assign mem_be     = (q.st == ST_WR) ? dst_be : src_be;
    assign mem_wdata  = (q.st == ST_WR) ? wr_data : 32'h0;
    assign periph_ack = beat_done;
    assign irq        = q.done & q.irq_en;

    // taps for the bound checker
    logic       cfg_en;
    logic       eng_idle;
    logic [1:0] cfg_dst_sz;
    assign cfg_en     = q.en;
    assign eng_idle   = (q.st == ST_IDLE);
    assign cfg_dst_sz = q.dst_sz;

endmodule

// File: rtl/dma_circ_chan_chk.sv
module dma_circ_chan_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_busy,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_be,
    input logic          periph_ack,
    input logic          cfg_en,
    input logic          eng_idle,
    input logic [1:0]    cfg_dst_sz
);
    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_busy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

    // R1
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && !mem_busy |=> !mem_req ##1 (mem_req && mem_we));

    // R1
    ack_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> mem_req && mem_we && !mem_busy);

    // R2
    be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> $countones(mem_be) ==
            ((cfg_dst_sz == 2'd0) ? 1 : ((cfg_dst_sz == 2'd1) ? 2 : 4)));

    // R7
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en && eng_idle |=> !mem_req);
endmodule

bind dma_circ_chan dma_circ_chan_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_busy   (mem_busy),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .periph_ack (periph_ack),
    .cfg_en     (cfg_en),
    .eng_idle   (eng_idle),
    .cfg_dst_sz (cfg_dst_sz)
);

// File: tb/test_dma_circ_chan.sv
module test_dma_circ_chan;
    localparam int AW = 32;
    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic        mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        mem_busy;
    logic        irq;

    logic        busy_mode = 1'b0;
    logic        busy_ovr = 1'b0;
    logic        busy_val = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic        clr_dest = 1'b0;
    logic [7:0]  mem_b [0:255];
    logic [7:0]  exp_b [0:255];
    int          bus_acc = 0;
    int          ack_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          ended = 0;

    always #4 clk = ~clk;

    dma_circ_chan #(.AW(AW), .CW(CW)) i_dma_circ_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .periph_ack(periph_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_busy(mem_busy), .irq(irq)
    );

    function automatic logic [7:0] src_val(input int a);
        return 8'(a * 13 + 5);
    endfunction

    function automatic logic [31:0] exp_word(input int a);
        return {src_val(a + 3), src_val(a + 2), src_val(a + 1), src_val(a)};
    endfunction

    function automatic logic [31:0] mem_word(input int a);
        return {mem_b[a + 3], mem_b[a + 2], mem_b[a + 1], mem_b[a]};
    endfunction

    assign mem_busy = busy_ovr ? busy_val : (busy_mode & lfsr[0]);

    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    // bus slave model: data returns one cycle after an accepted read
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) mem_b[a] <= (a < 128) ? src_val(a) : 8'hEE;
        end else begin
            if (clr_dest)
                for (int a = 'h80; a < 'hC0; a++) mem_b[a] <= 8'hEE;
            if (mem_req && !mem_busy) begin
                bus_acc <= bus_acc + 1;
                if (mem_we) begin
                    for (int l = 0; l < 4; l++)
                        if (mem_be[l]) mem_b[{mem_addr[7:2], 2'(l)}] <= mem_wdata[8*l +: 8];
                end else begin
                    mem_rdata <= {mem_b[{mem_addr[7:2], 2'd3}], mem_b[{mem_addr[7:2], 2'd2}],
                                  mem_b[{mem_addr[7:2], 2'd1}], mem_b[{mem_addr[7:2], 2'd0}]};
                end
            end
            if (periph_ack) ack_cnt <= ack_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic dest_clear();
        @(negedge clk) clr_dest = 1'b1;
        @(negedge clk) clr_dest = 1'b0;
    endtask

    task automatic one_req();
        int base;
        int t;
        base = ack_cnt;
        @(negedge clk) periph_req = 1'b1;
        t = 0;
        while (ack_cnt == base && t < 200) begin
            @(negedge clk);
            t++;
        end
        periph_req = 1'b0;
        chk(ack_cnt != base, "R1 request acknowledged", 32'(ack_cnt - base), 32'd1);
    endtask

    task automatic run_cfg(input int ss, input int ds, input int si, input int di, input int nb);
        logic [31:0] rv;
        int sb, db, s0, d0, ack0, acc0, bad, irqen;
        sb = 1 << ss; db = 1 << ds;
        s0 = 'h10 + ((ss == 0) ? 1 : ((ss == 1) ? 2 : 0));
        d0 = 'h80 + ((ds == 0) ? 3 : ((ds == 1) ? 2 : 0));
        irqen = (ss + ds + si) % 2;
        for (int a = 'h80; a < 'hC0; a++) exp_b[a] = 8'hEE;
        for (int k = 0; k < nb; k++) begin
            int sa, da;
            sa = s0 + (si != 0 ? k * sb : 0);
            da = d0 + (di != 0 ? k * db : 0);
            for (int i = 0; i < db; i++) exp_b[da + i] = (i < sb) ? src_val(sa + i) : 8'h00;
        end
        dest_clear();
        reg_wr(3'd1, 32'(s0));
        reg_wr(3'd3, 32'(d0));
        reg_wr(3'd4, 32'(nb));
        reg_wr(3'd5, 32'd1);
        reg_wr(3'd0, 32'(1 | (irqen << 3) | (si << 4) | (di << 5) | (ss << 6) | (ds << 8)));
        reg_rd(3'd6, rv);
        chk(rv == 32'(nb), "R11 remaining count after enable", rv, 32'(nb));
        ack0 = ack_cnt; acc0 = bus_acc;
        for (int k = 0; k < nb; k++) one_req();
        repeat (3) @(negedge clk);
        chk(bus_acc - acc0 == 2 * nb, "R1 two bus beats per request", 32'(bus_acc - acc0), 32'(2 * nb));
        bad = 0;
        for (int a = 'h80; a < 'hC0; a++)
            if (mem_b[a] !== exp_b[a]) begin
                if (bad == 0)
                    chk(1'b0, $sformatf("R2 R3 dest byte %0h (ss%0d ds%0d si%0d di%0d)", a, ss, ds, si, di),
                        32'(mem_b[a]), 32'(exp_b[a]));
                bad++;
            end
        if (bad == 0) chk(1'b1, "R2 R3 dest image", 0, 0);
        reg_rd(3'd5, rv);
        chk(rv[0] == 1'b1, "R5 done flag set", rv, 32'd1);
        chk(irq == irqen[0], "R5 irq follows enable", 32'(irq), 32'(irqen));
        reg_rd(3'd0, rv);
        chk(rv[0] == 1'b0, "R7 enable cleared at completion", rv, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int ack0, acc0, t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        reg_rd(3'd0, rv); chk(rv == 0, "R12 CTRL after reset", rv, 0);
        reg_rd(3'd5, rv); chk(rv == 0, "R12 STATUS after reset", rv, 0);
        reg_rd(3'd6, rv); chk(rv == 0, "R12 remaining after reset", rv, 0);
        chk(!irq && !mem_req, "R12 outputs idle after reset", {30'd0, irq, mem_req}, 0);
        reg_wr(3'd2, 32'h40);
        reg_rd(3'd2, rv); chk(rv == 32'h40, "R12 source B readback", rv, 32'h40);

        // sweep all size / increment combinations under a busy pattern
        busy_mode = 1'b1;
        for (int ss = 0; ss < 3; ss++)
            for (int ds = 0; ds < 3; ds++)
                for (int si = 0; si < 2; si++)
                    for (int di = 0; di < 2; di++)
                        run_cfg(ss, ds, si, di, 4);
        busy_mode = 1'b0;

        // circular: count 2, three requests
        dest_clear();
        reg_wr(3'd1, 32'h20); reg_wr(3'd3, 32'h90); reg_wr(3'd4, 32'd2); reg_wr(3'd5, 32'd1);
        reg_wr(3'd0, 32'h2B3);
        one_req(); one_req();
        repeat (2) @(negedge clk);
        reg_rd(3'd6, rv); chk(rv == 2, "R8 count reloaded", rv, 2);
        reg_rd(3'd0, rv); chk(rv[0] == 1'b1, "R8 stays enabled", rv, 1);
        chk(irq == 1'b0, "R5 irq low with enable off", 32'(irq), 0);
        reg_rd(3'd5, rv); chk(rv[0] == 1'b1, "R5 flag set in circular", rv, 1);
        reg_wr(3'd5, 32'd1);
        reg_rd(3'd5, rv); chk(rv[0] == 1'b0, "R6 write-one clears flag", rv, 0);
        dest_clear();
        one_req();
        repeat (2) @(negedge clk);
        chk(mem_word('h90) == exp_word('h20), "R8 pass two restarts at programmed addresses",
            mem_word('h90), exp_word('h20));
        chk(mem_word('h94) == 32'hEEEEEEEE, "R8 only one beat of pass two", mem_word('h94), 32'hEEEEEEEE);
        reg_rd(3'd6, rv); chk(rv == 1, "R8 remaining after one beat", rv, 1);
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd6, 32'h0);  // read-only offset: no effect expected
        reg_rd(3'd6, rv); chk(rv == 1, "R12 remaining is read-only", rv, 1);

        // double buffer: count 2, four requests
        dest_clear();
        reg_wr(3'd1, 32'h20); reg_wr(3'd2, 32'h40); reg_wr(3'd3, 32'hA0); reg_wr(3'd4, 32'd2);
        reg_wr(3'd0, 32'h2B7);
        one_req(); one_req();
        repeat (2) @(negedge clk);
        reg_rd(3'd5, rv); chk(rv[1] == 1'b1, "R9 buffer bit toggled", rv, 32'h3);
        chk(mem_word('hA4) == exp_word('h24), "R9 first pass from source A", mem_word('hA4), exp_word('h24));
        one_req(); one_req();
        repeat (2) @(negedge clk);
        reg_rd(3'd5, rv); chk(rv[1] == 1'b0, "R9 buffer bit toggled back", rv, 32'h1);
        chk(mem_word('hA0) == exp_word('h40), "R9 second pass from source B", mem_word('hA0), exp_word('h40));
        chk(mem_word('hA4) == exp_word('h44), "R9 second pass second beat", mem_word('hA4), exp_word('h44));
        reg_wr(3'd0, 32'h0);

        // completion and clear in the same cycle, with a stalled write
        dest_clear();
        reg_wr(3'd5, 32'd1);
        reg_wr(3'd1, 32'h30); reg_wr(3'd3, 32'hB0); reg_wr(3'd4, 32'd1);
        busy_ovr = 1'b1; busy_val = 1'b0;
        reg_wr(3'd0, 32'h281);
        periph_req = 1'b1;
        t = 0;
        while (!(mem_req && mem_we) && t < 50) begin
            @(negedge clk);
            t++;
        end
        busy_val = 1'b1;
        periph_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req && mem_we && mem_addr == 32'hB0, "R4 write held while busy", mem_addr, 32'hB0);
        chk(mem_word('hB0) == 32'hEEEEEEEE, "R4 no write while busy", mem_word('hB0), 32'hEEEEEEEE);
        busy_val = 1'b0;
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'd1;
        @(negedge clk);
        reg_we = 1'b0; busy_ovr = 1'b0;
        @(negedge clk);
        reg_rd(3'd5, rv); chk(rv[0] == 1'b1, "R6 completion beats clear", rv, 1);
        chk(mem_word('hB0) == exp_word('h30), "R4 write after release", mem_word('hB0), exp_word('h30));

        // zero count
        reg_wr(3'd5, 32'd1);
        reg_wr(3'd4, 32'd0);
        acc0 = bus_acc;
        reg_wr(3'd0, 32'h281);
        repeat (3) @(negedge clk);
        reg_rd(3'd5, rv); chk(rv[0] == 1'b1, "R10 zero count sets flag", rv, 1);
        reg_rd(3'd0, rv); chk(rv[0] == 1'b0, "R10 zero count disables", rv, 0);
        chk(bus_acc == acc0, "R10 zero count has no bus access", 32'(bus_acc - acc0), 0);

        // disabled channel ignores requests
        ack0 = ack_cnt; acc0 = bus_acc;
        @(negedge clk) periph_req = 1'b1;
        repeat (10) @(negedge clk);
        periph_req = 1'b0;
        chk(ack_cnt == ack0, "R7 no acknowledge when disabled", 32'(ack_cnt - ack0), 0);
        chk(bus_acc == acc0, "R7 no bus access when disabled", 32'(bus_acc - acc0), 0);

        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule